// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

This block is a compact 4-bit processor built around one shared internal nibble bus. Program words are 8 bits wide: the upper nibble selects the operation and the lower nibble carries an immediate operand. The core fetches each word into an instruction register, then walks it through a fixed ring of four one-hot steps. In each step at most one source drives the bus and one or two registers capture from it. Every register changes on the falling clock edge.

The program lives in a 16-word store inside the block. The store can be written through a simple write port only while clear is held. After clear is released, execution starts at address zero. The supported operations are: load the accumulator from the immediate, add or subtract the immediate, load from an external input nibble, and copy the accumulator to the output register. Every other opcode parks the core at its current address. A carry flag records the carry out of the last addition or subtraction and is visible on a port.

Top module: `nib4_core`

## Requirements
- R1: While `clr` is high, every falling edge zeroes `out_bus`, `carry_out`, the program counter and the step ring. After `clr` drops, one falling edge starts the ring, and the first instruction is fetched from address 0.
- R2: Each instruction occupies exactly four falling edges. An output copy becomes visible on `out_bus` after the third of its four edges and not before.
- R3: Opcode 0 (upper nibble `4'h0`) loads the accumulator with the word's low nibble.
- R4: Opcode 1 adds the low nibble to the accumulator modulo 16. `carry_out` becomes the carry out of that 4-bit sum.
- R5: Opcode 2 computes accumulator + (~nibble) + 1 modulo 16. `carry_out` becomes the carry of that sum, which is 1 exactly when the accumulator is not less than the nibble.
- R6: Opcode 3 loads the accumulator from `in_bus`, sampled at the instruction's second falling edge.
- R7: Opcode 4 copies the accumulator to `out_bus`. The output keeps that value until the next opcode 4 or a clear.
- R8: Opcodes 5 through 15 change nothing and hold the program counter, so the core stays at that word.
- R9: A program store write (`prog_we` high) takes effect at a falling edge only while `clr` is high. Writes attempted while `clr` is low are ignored.
- R10: `carry_out` changes only on opcodes 1 and 2 and holds through all other instructions.
- R11: The program counter wraps from address 15 back to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| clr | input | 1 | Synchronous active-high clear; also unlocks program writes |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program store write address |
| prog_wdata | input | 8 | Program word: opcode in bits 7:4, operand in bits 3:0 |
| in_bus | input | 4 | External data nibble read by opcode 3 |
| out_bus | output | 4 | Output register contents |
| carry_out | output | 1 | Carry flag from the last add or subtract |

## Verification
The arithmetic program 5+2, +4, then C−4 is run to confirm the visible sequence 7, B, 8. This pins down add, subtract and output ordering together. Seeded random programs that mix all five operations with random immediates and input nibbles separate carry behaviour on wrap and on borrow, show that the carry holds across non-arithmetic steps, and confirm that `in_bus` is sampled at the right step. Directed cases cover the rest: a parking opcode followed by live output words shows the counter really holds. A full 16-word program without parking shows the address wraps. A write attempted mid-run to a later output word shows the store is locked outside clear. A mid-output check one half-instruction early shows the output copy does not appear before its step.

// File: rtl/nib4_pkg.sv
package nib4_pkg;

    parameter int unsigned DW    = 4;
    parameter int unsigned AW    = 4;
    parameter int unsigned WW    = 2 * DW;
    parameter int unsigned DEPTH = 1 << AW;
    parameter int unsigned NPH   = 4;

    typedef logic [DW-1:0]  nib_t;
    typedef logic [AW-1:0]  addr_t;
    typedef logic [WW-1:0]  word_t;
    typedef logic [NPH-1:0] phase_t;

    localparam nib_t OP_LDA = nib_t'(0);
    localparam nib_t OP_ADD = nib_t'(1);
    localparam nib_t OP_SUB = nib_t'(2);
    localparam nib_t OP_IN  = nib_t'(3);
    localparam nib_t OP_OUT = nib_t'(4);

    typedef struct packed {
        logic ld_ir;
        logic ld_a;
        logic ld_b;
        logic ld_out;
        logic ld_c;
        logic inc_pc;
        logic sub;
        logic en_ir;
        logic en_a;
        logic en_in;
        logic en_alu;
    } ctrl_t;

    function automatic nib_t word_op(input word_t w);
        return w[WW-1 -: DW];
    endfunction

    function automatic nib_t word_arg(input word_t w);
        return w[DW-1:0];
    endfunction

    function automatic logic is_exec(input nib_t op);
        return op <= OP_OUT;
    endfunction

endpackage

// File: rtl/nib4_phase_ring.sv
module nib4_phase_ring
    import nib4_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    output phase_t ph
);

    always_ff @(negedge clk) begin
        if (clr)
            ph <= '0;
        else if (ph == '0)
            ph <= phase_t'(1);
        else
            ph <= {ph[NPH-2:0], ph[NPH-1]};
    end

    a_r2_ring_onehot: assert property (@(negedge clk) disable iff (clr)
        1'b1 |=> ($countones(ph) == 1));

    a_r2_ring_first: assert property (@(negedge clk) disable iff (clr)
        ph[0] |=> ph[1]);

    a_r2_ring_last: assert property (@(negedge clk) disable iff (clr)
        ph[NPH-1] |=> ph[0]);

endmodule

// File: rtl/nib4_prog_store.sv
module nib4_prog_store
    import nib4_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);

    word_t mem [DEPTH];

    always_ff @(negedge clk) begin
        if (clr && we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nib4_ctrl.sv
module nib4_ctrl
    import nib4_pkg::*;
(
    input  phase_t ph,
    input  nib_t   op,
    output ctrl_t  ctl
);

    always_comb begin
        ctl     = '0;
        ctl.sub = (op == OP_SUB);
        if (ph[0]) begin
            ctl.ld_ir = 1'b1;
        end else if (ph[1]) begin
            case (op)
                OP_LDA:         begin ctl.en_ir = 1'b1; ctl.ld_a = 1'b1; end
                OP_ADD, OP_SUB: begin ctl.en_ir = 1'b1; ctl.ld_b = 1'b1; end
                OP_IN:          begin ctl.en_in = 1'b1; ctl.ld_a = 1'b1; end
                default:        ;
            endcase
        end else if (ph[2]) begin
            case (op)
                OP_ADD, OP_SUB: begin ctl.en_alu = 1'b1; ctl.ld_a = 1'b1; ctl.ld_c = 1'b1; end
                OP_OUT:         begin ctl.en_a = 1'b1; ctl.ld_out = 1'b1; end
                default:        ;
            endcase
        end else if (ph[3]) begin
            ctl.inc_pc = is_exec(op);
        end
    end

endmodule

// File: rtl/nib4_addsub.sv
module nib4_addsub
    import nib4_pkg::*;
(
    input  nib_t a,
    input  nib_t b,
    input  logic sub,
    output nib_t sum,
    output logic cy
);

    logic [DW:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{DW{1'b0}}, sub};
        sum  = wide[DW-1:0];
        cy   = wide[DW];
    end

endmodule

// File: rtl/nib4_core.sv
module nib4_core
    import nib4_pkg::*;
(
    input  logic          clk,
    input  logic          clr,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [WW-1:0] prog_wdata,
    input  logic [DW-1:0] in_bus,
    output logic [DW-1:0] out_bus,
    output logic          carry_out
);

    phase_t ph;
    ctrl_t  ctl;
    addr_t  pc_q;
    word_t  ir_q, rd_word;
    nib_t   a_q, b_q, out_q, alu_sum, bus;
    logic   c_q, alu_cy;
    nib_t   op;

    assign op = word_op(ir_q);

    nib4_phase_ring u_ring (.clk(clk), .clr(clr), .ph(ph));

    nib4_prog_store u_store (
        .clk(clk), .clr(clr), .we(prog_we), .waddr(prog_addr),
        .wdata(prog_wdata), .raddr(pc_q), .rdata(rd_word)
    );

    nib4_ctrl u_ctrl (.ph(ph), .op(op), .ctl(ctl));

    nib4_addsub u_alu (.a(a_q), .b(b_q), .sub(ctl.sub), .sum(alu_sum), .cy(alu_cy));

    always_comb begin
        bus = '0;
        if (ctl.en_ir)  bus = bus | word_arg(ir_q);
        if (ctl.en_a)   bus = bus | a_q;
        if (ctl.en_in)  bus = bus | in_bus;
        if (ctl.en_alu) bus = bus | alu_sum;
    end

    always_ff @(negedge clk) begin
        if (clr) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            out_q <= '0;
            c_q   <= 1'b0;
        end else begin
            if (ctl.ld_ir)  ir_q  <= rd_word;
            if (ctl.ld_a)   a_q   <= bus;
            if (ctl.ld_b)   b_q   <= bus;
            if (ctl.ld_out) out_q <= bus;
            if (ctl.ld_c)   c_q   <= alu_cy;
            if (ctl.inc_pc) pc_q  <= pc_q + addr_t'(1);
        end
    end

    assign out_bus   = out_q;
    assign carry_out = c_q;

    a_r1_clear_zero: assert property (@(negedge clk)
        clr |=> (out_q == '0 && c_q == 1'b0 && pc_q == '0));

    a_r2_one_driver: assert property (@(negedge clk) disable iff (clr)
        $countones({ctl.en_ir, ctl.en_a, ctl.en_in, ctl.en_alu}) <= 1);

    a_r8_park_pc: assert property (@(negedge clk) disable iff (clr)
        (ph[3] && !is_exec(op)) |=> $stable(pc_q));

    a_r7_out_hold: assert property (@(negedge clk) disable iff (clr)
        !ctl.ld_out |=> $stable(out_q));

    a_r10_carry_hold: assert property (@(negedge clk) disable iff (clr)
        !ctl.ld_c |=> $stable(c_q));

endmodule

// File: tb/test_nib4_core.sv
module test_nib4_core;
    import nib4_pkg::*;

    logic  clk = 1'b0;
    logic  clr = 1'b1;
    logic  we  = 1'b0;
    addr_t wa  = '0;
    word_t wd  = '0;
    nib_t  inb = '0;
    nib_t  ob;
    logic  co;

    always #2 clk = ~clk;

    nib4_core i_nib4_core (
        .clk(clk), .clr(clr), .prog_we(we), .prog_addr(wa),
        .prog_wdata(wd), .in_bus(inb), .out_bus(ob), .carry_out(co)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    word_t prog_m [DEPTH];
    nib_t  ins_m  [64];
    int    m_pc, m_a, m_out, m_c;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input nib_t op);
        case (op)
            OP_LDA:  return "R3 load immediate";
            OP_ADD:  return "R4 add";
            OP_SUB:  return "R5 subtract";
            OP_IN:   return "R6 input load";
            OP_OUT:  return "R7 output copy";
            default: return "R8 parked";
        endcase
    endfunction

    task automatic load_and_clear();
        @(posedge clk);
        clr = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            we = 1'b1; wa = addr_t'(i); wd = prog_m[i];
            @(posedge clk);
        end
        we = 1'b0;
        @(posedge clk);
        chk("R1 out under clear", ob, 0);
        chk("R1 carry under clear", co, 0);
        m_pc = 0; m_a = 0; m_out = 0; m_c = 0;
        clr = 1'b0;
        @(negedge clk);
        @(posedge clk);
    endtask

    task automatic run_n(input int n, input bit bad_wr);
        for (int k = 0; k < n; k++) begin
            word_t w;
            nib_t  op, d;
            int    prev_out, t;
            inb = ins_m[k % 64];
            w   = prog_m[m_pc];
            op  = word_op(w);
            d   = word_arg(w);
            prev_out = m_out;
            case (op)
                OP_LDA: m_a = d;
                OP_ADD: begin t = m_a + d; m_a = t % 16; m_c = t / 16; end
                OP_SUB: begin t = m_a + (15 - d) + 1; m_a = t % 16; m_c = t / 16; end
                OP_IN:  m_a = inb;
                OP_OUT: m_out = m_a;
                default: ;
            endcase
            if (is_exec(op)) m_pc = (m_pc + 1) % DEPTH;
            if (bad_wr && k == 0) begin
                we = 1'b1; wa = addr_t'(1); wd = 8'hF0;
            end
            repeat (2) @(negedge clk);
            @(posedge clk);
            we = 1'b0;
            chk("R2 output not early", ob, prev_out);
            repeat (2) @(negedge clk);
            @(posedge clk);
            chk(tag_of(op), ob, m_out);
            chk("R10 carry", co, m_c);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) ins_m[i] = nib_t'($urandom % 16);

        // R4 R5 R7: 5+2=7, +4=B, C-4=8, then park
        for (int i = 0; i < DEPTH; i++) prog_m[i] = 8'hF0;
        prog_m[0] = 8'h05; prog_m[1] = 8'h12; prog_m[2] = 8'h40;
        prog_m[3] = 8'h14; prog_m[4] = 8'h40; prog_m[5] = 8'h0C;
        prog_m[6] = 8'h24; prog_m[7] = 8'h40;
        load_and_clear();
        run_n(10, 1'b0);
        chk("R5 sequence final value", ob, 8);
        chk("R5 no-borrow carry", co, 1);

        // R1: clear while running drops output and carry
        @(posedge clk);
        clr = 1'b1;
        @(negedge clk);
        @(posedge clk);
        chk("R1 clear mid-run out", ob, 0);
        chk("R1 clear mid-run carry", co, 0);

        // R8: parking opcode holds before later live words
        for (int i = 0; i < DEPTH; i++) prog_m[i] = 8'h40;
        prog_m[0] = 8'h03; prog_m[1] = 8'h40; prog_m[2] = 8'h5A;
        prog_m[3] = 8'h09;
        load_and_clear();
        run_n(8, 1'b0);
        chk("R8 park keeps output", ob, 3);

        // R9: write while running is ignored
        for (int i = 0; i < DEPTH; i++) prog_m[i] = 8'hF0;
        prog_m[0] = 8'h09; prog_m[1] = 8'h40;
        load_and_clear();
        run_n(3, 1'b1);
        chk("R9 locked store", ob, 9);

        // R11: wrap from 15 to 0
        for (int i = 0; i < DEPTH - 1; i++) prog_m[i] = 8'h11;
        prog_m[DEPTH-1] = 8'h40;
        load_and_clear();
        run_n(17, 1'b0);
        chk("R11 out before wrap", ob, 15);
        chk("R11 carry after wrap", co, 1);

        // random programs
        for (int p = 0; p < 12; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                int r;
                nib_t o;
                r = $urandom % 16;
                o = (r < 15) ? nib_t'(r % 5) : nib_t'(5 + ($urandom % 11));
                prog_m[i] = {o, nib_t'($urandom % 16)};
            end
            for (int i = 0; i < 64; i++) ins_m[i] = nib_t'($urandom % 16);
            load_and_clear();
            run_n(24, 1'b0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule